// File: doc/BRIEF.md
# Transmit Link Bring-Up Sequencer

This block is a small control state machine that brings the transmit side of a high-speed packet interface out of reset. It runs after the block reset is released or when a restart is requested. It keeps the link logic disabled and held in reset while it works. It then sends a fixed-width reset pulse to the clock generator and waits until the clocks are reported stable. After that it lets the link logic out of reset and, if the link needs one, runs a calendar-load handshake. Enabling the link is always the last step.

The clocks-ready input may come from another clock domain, so it passes through a flop chain before the state machine uses it. When the clocks come from an external source, a build parameter removes the generator reset pulse, but the block still waits for clocks-ready. A start request at any point throws away the progress made so far and begins again from the held state.

Top module: `tx_bringup_seq`

## Requirements
- R1: While the block reset is low, and in the first cycle after a start request is sampled, the outputs are: enable low, core reset asserted (`core_rst_n_o` = 0), generator reset low, calendar request low, `done_o` low and `busy_o` high.
- R2: With the internal generator selected, `clkgen_rst_o` is high for exactly PULSE_W consecutive cycles. The pulse begins in the cycle after the held state and is issued once per sequence.
- R3: `core_rst_n_o` stays 0 until clocks-ready has passed the synchronizer and the generator pulse has ended. With SYNC_STAGES = 2, the release shows in the third cycle after clocks-ready is first sampled high, and never before the cycle after the pulse.
- R4: `cal_need_i` is sampled in the cycle in which the core reset is released. When it is 1, `cal_req_o` rises in the next cycle and stays high until `cal_done_i` is sampled high. During that time the core reset stays released and the enable stays low. When it is 0, no request is made.
- R5: `link_en_o` rises in the cycle after `cal_done_i` is sampled during the request, or in the cycle after the release when no calendar is needed. It then stays high until a restart.
- R6: With USE_INT_CLKGEN = 0, `clkgen_rst_o` never goes high. The block goes from the held state straight to waiting for clocks-ready.
- R7: A start request sampled in any state returns the block to the held state. Any pulse, wait, calendar request or enable in progress ends at once.
- R8: `done_o` is high exactly when the enable is high, and `busy_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| start_i | input | 1 | Restart request, sampled every cycle |
| clk_rdy_i | input | 1 | Clocks-stable indication, asynchronous |
| cal_need_i | input | 1 | Calendar must be loaded before enable |
| cal_done_i | input | 1 | Calendar load finished |
| clkgen_rst_o | output | 1 | Reset pulse to the clock generator |
| core_rst_n_o | output | 1 | Link logic reset, active low |
| cal_req_o | output | 1 | Calendar load request |
| link_en_o | output | 1 | Link enable |
| done_o | output | 1 | Sequence complete |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench builds two copies of the block from one set of stimulus. One keeps the defaults: internal generator, PULSE_W = 4 and two synchronizer stages. The other is built with USE_INT_CLKGEN = 0. Because the two copies are compared cycle by cycle, the bench can check both the case where the generator pulse sets the release time and the case where a late clocks-ready sets it, and it can confirm that the external-clock build skips the pulse. Restart requests are issued during the wait, during the calendar request and while the link is enabled.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_PULSE   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_RELEASE = 3'd3,
    ST_CAL     = 3'd4,
    ST_RUN     = 3'd5
  } tbs_state_e;

  // true when the cycle counted by cnt (0-based) is the last of a w-cycle pulse
  function automatic logic pulse_over(input int unsigned cnt, input int unsigned w);
    return (cnt + 1) >= w;
  endfunction

  // index of the first sample with the core reset released, counted from the held state
  function automatic int unsigned release_cycle(input int unsigned rdy_at,
                                                input int unsigned stages,
                                                input int unsigned pulse_w);
    int unsigned a;
    int unsigned b;
    a = rdy_at + stages + 1;
    b = pulse_w + 2;
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tbs_sync.sv
module tbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/tbs_pulse_timer.sv
module tbs_pulse_timer #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (!last_o) cnt <= cnt + CW'(1);
  end

  assign last_o = tbs_pkg::pulse_over(32'(cnt), 32'(PULSE_W));
endmodule

// File: rtl/tbs_fsm.sv
module tbs_fsm
  import tbs_pkg::*;
#(
  parameter bit USE_INT_CLKGEN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rdy_sync_i,
  input  logic       pulse_last_i,
  input  logic       cal_need_i,
  input  logic       cal_done_i,
  output tbs_state_e state_o
);
  tbs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD:    st_d = USE_INT_CLKGEN ? ST_PULSE : ST_WAIT;
        ST_PULSE:   if (pulse_last_i) st_d = ST_WAIT;
        ST_WAIT:    if (rdy_sync_i) st_d = ST_RELEASE;
        ST_RELEASE: st_d = cal_need_i ? ST_CAL : ST_RUN;
        ST_CAL:     if (cal_done_i) st_d = ST_RUN;
        ST_RUN:     st_d = ST_RUN;
        default:    st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/tx_bringup_seq.sv
module tx_bringup_seq
  import tbs_pkg::*;
#(
  parameter int PULSE_W        = 4,
  parameter int SYNC_STAGES    = 2,
  parameter bit USE_INT_CLKGEN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clk_rdy_i,
  input  logic cal_need_i,
  input  logic cal_done_i,
  output logic clkgen_rst_o,
  output logic core_rst_n_o,
  output logic cal_req_o,
  output logic link_en_o,
  output logic done_o,
  output logic busy_o
);
  logic       rdy_sync;
  logic       pulse_run;
  logic       pulse_last;
  tbs_state_e state;

  tbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(clk_rdy_i), .q_o(rdy_sync)
  );

  assign pulse_run = (state == ST_PULSE);

  generate
    if (USE_INT_CLKGEN) begin : g_int
      tbs_pulse_timer #(.PULSE_W(PULSE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(pulse_run), .last_o(pulse_last)
      );
    end else begin : g_ext
      assign pulse_last = 1'b1;
    end
  endgenerate

  tbs_fsm #(.USE_INT_CLKGEN(USE_INT_CLKGEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdy_sync_i(rdy_sync),
    .pulse_last_i(pulse_last), .cal_need_i(cal_need_i),
    .cal_done_i(cal_done_i), .state_o(state)
  );

  assign clkgen_rst_o = pulse_run;
  assign core_rst_n_o = (state == ST_RELEASE) || (state == ST_CAL) || (state == ST_RUN);
  assign cal_req_o    = (state == ST_CAL);
  assign link_en_o    = (state == ST_RUN);
  assign done_o       = (state == ST_RUN);
  assign busy_o       = (state != ST_RUN);
endmodule

// File: rtl/tbs_chk.sv
module tbs_chk #(
  parameter int PULSE_W        = 4,
  parameter bit USE_INT_CLKGEN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic rdy_sync,
  input logic cal_done_i,
  input logic clkgen_rst_o,
  input logic core_rst_n_o,
  input logic cal_req_o,
  input logic link_en_o,
  input logic done_o,
  input logic busy_o
);
  localparam int CW = $clog2(PULSE_W + 2);
  logic [CW-1:0] plen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            plen <= '0;
    else if (!clkgen_rst_o) plen <= '0;
    else if (int'(plen) <= PULSE_W) plen <= plen + CW'(1);
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkgen_rst_o |-> (int'(plen) < PULSE_W));

  // R2
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkgen_rst_o |-> (!core_rst_n_o && !link_en_o && !cal_req_o));

  // R3
  release_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n_o) |-> $past(rdy_sync));

  // R4
  cal_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |-> (core_rst_n_o && !link_en_o));

  // R4
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req_o && !cal_done_i && !start_i) |=> cal_req_o);

  // R5
  enable_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en_o) |-> (core_rst_n_o && !cal_req_o && !clkgen_rst_o));

  // R6
  ext_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !USE_INT_CLKGEN |-> !clkgen_rst_o);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!link_en_o && !core_rst_n_o && !cal_req_o && !clkgen_rst_o));

  // R8
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o == link_en_o) && (busy_o != link_en_o));
endmodule

bind tx_bringup_seq tbs_chk #(.PULSE_W(PULSE_W), .USE_INT_CLKGEN(USE_INT_CLKGEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdy_sync(rdy_sync),
  .cal_done_i(cal_done_i), .clkgen_rst_o(clkgen_rst_o), .core_rst_n_o(core_rst_n_o),
  .cal_req_o(cal_req_o), .link_en_o(link_en_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/tx_bringup_seq_bench.sv
module tx_bringup_seq_bench;
  localparam int CLK_P  = 10;
  localparam int PW     = 4;
  localparam int STAGES = 2;
  localparam int NVEC   = 6;
  // {cal_need, cycle of clocks-ready rise, cycles of calendar request}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'd1,  8'd0},
    {1'b1, 8'd1,  8'd1},
    {1'b1, 8'd2,  8'd3},
    {1'b0, 8'd8,  8'd0},
    {1'b1, 8'd10, 8'd5},
    {1'b0, 8'd3,  8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clk_rdy = 1'b0, cal_need = 1'b0, cal_done = 1'b0;
  logic gr_i, cr_i, cq_i, en_i, dn_i, bz_i;
  logic gr_e, cr_e, cq_e, en_e, dn_e, bz_e;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tx_bringup_seq #(.PULSE_W(PW), .SYNC_STAGES(STAGES), .USE_INT_CLKGEN(1'b1)) u_tx_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clk_rdy_i(clk_rdy),
    .cal_need_i(cal_need), .cal_done_i(cal_done),
    .clkgen_rst_o(gr_i), .core_rst_n_o(cr_i), .cal_req_o(cq_i),
    .link_en_o(en_i), .done_o(dn_i), .busy_o(bz_i)
  );

  tx_bringup_seq #(.PULSE_W(PW), .SYNC_STAGES(STAGES), .USE_INT_CLKGEN(1'b0)) u_tx_bringup_seq_ext (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clk_rdy_i(clk_rdy),
    .cal_need_i(1'b0), .cal_done_i(1'b0),
    .clkgen_rst_o(gr_e), .core_rst_n_o(cr_e), .cal_req_o(cq_e),
    .link_en_o(en_e), .done_o(dn_e), .busy_o(bz_e)
  );

  task automatic chk(input string req, input int k, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // stop_k = 0 runs to two cycles past enable; otherwise abort after sample stop_k
  task automatic run_seq(input bit need, input int r, input int c, input int stop_k);
    int rel_i, rel_e, en_k, last;
    rel_i = (r + STAGES + 1 > PW + 2) ? r + STAGES + 1 : PW + 2;
    rel_e = r + STAGES + 1;
    en_k  = need ? rel_i + c + 1 : rel_i + 1;
    last  = (stop_k != 0) ? stop_k : ((en_k > rel_e + 1 ? en_k : rel_e + 1) + 2);
    @(negedge clk);
    start = 1'b1; clk_rdy = 1'b0; cal_done = 1'b0; cal_need = need;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      // R1 R7: held state at k = 0
      chk("R2 pulse", k, gr_i, (k >= 1 && k <= PW));
      chk("R3 release", k, cr_i, (k >= rel_i));
      chk("R4 calendar", k, cq_i, need && (k > rel_i) && (k <= rel_i + c));
      chk("R5 enable", k, en_i, (k >= en_k));
      chk("R8 done", k, dn_i, (k >= en_k));
      chk("R8 busy", k, bz_i, (k < en_k));
      chk("R6 ext pulse", k, gr_e, 1'b0);
      chk("R6 ext release", k, cr_e, (k >= rel_e));
      chk("R6 ext enable", k, en_e, (k >= rel_e + 1));
      clk_rdy  = (k >= r);
      cal_done = need && (k == rel_i + c);
    end
    cal_done = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during block reset
    chk("R1 reset en", 0, en_i, 1'b0);
    chk("R1 reset core", 0, cr_i, 1'b0);
    chk("R1 reset gen", 0, gr_i, 1'b0);
    chk("R1 reset busy", 0, bz_i, 1'b1);
    rst_n = 1'b1;
    // start is raised right away so both copies begin from the held state together
    for (int i = 0; i < NVEC; i++)
      run_seq(VEC[i][16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 0);
    // R7: restart while waiting for clocks, then during calendar request, then from run
    run_seq(1'b1, 20, 2, 7);
    run_seq(1'b1, 1, 6, 9);
    run_seq(1'b0, 2, 0, 0);
    run_seq(1'b1, 4, 2, 0);
    finish_run();
  end
endmodule